// File: doc/BRIEF.md
# I2C Error and Status Flag Unit

This unit collects the error conditions of a two-wire serial peripheral that can run as bus master or as slave. It watches the already synchronized clock and data lines, and it takes event strobes from the byte engine that sits beside it: a received byte is complete, a byte must be sent, an acknowledge bit was sampled, a packet-error-check byte was compared. It also takes the current transfer phase. From these it raises five sticky flags, decides whether to acknowledge a received check byte, and drops the unit out of master mode when arbitration is lost.

Software clears a flag by writing 0 to its bit position. Writing 1 leaves the bit alone. Taking the enable low clears every flag and the master mode bit. The byte engine reads `rx_drop` and `tx_repeat` to learn that a byte has to be discarded or sent again, and it reads `pec_ack` to choose the acknowledge it drives after the check byte.

Top module: `i2c_err_flags`

## Requirements
- R1: After reset, and in the cycle after `en` is sampled low, `flags`, `is_master`, `pec_ack_vld`, `rx_drop` and `tx_repeat` are all 0. While `en` is low no strobe sets anything. The flag positions are bit 0 bus error, bit 1 arbitration lost, bit 2 acknowledge failure, bit 3 overrun/underrun, bit 4 check-byte error.
- R2: A cycle with `clr_we`=1 clears each flag whose `clr_val` bit is 0 and keeps each flag whose bit is 1. A set condition in the same cycle wins over the clear.
- R3: One cycle after `pec_done`, `pec_ack_vld` is 1 for exactly one cycle. `pec_ack` is 1 only when `pec_match`=1 and `ack_en`=1, so a mismatch always gives a NACK.
- R4: `pec_done` with `pec_match`=0 sets flag bit 4 when the unit is master, or when it is slave with `pec_ctl`=1. As slave with `pec_ctl`=0 the flag stays clear.
- R5: As slave with `no_stretch`=1, `rx_done` while `dr_unread`=1 sets flag bit 3 and pulses `rx_drop` one cycle later. In master mode, or with `no_stretch`=0, neither happens.
- R6: Under the same slave and `no_stretch` condition, `tx_need` while `dr_loaded`=0 sets flag bit 3 and pulses `tx_repeat` one cycle later.
- R7: `ack_smp` with `ack_nack`=1 (no acknowledge received) sets flag bit 2. With `ack_nack`=0 the flag stays clear.
- R8: As master, an SCL rising edge that finds `sda_own`=1, `sda_drv`=1 and SDA low sets flag bit 1 and clears `is_master` in the same update.
- R9: As slave, that check runs only when `smbus`=1 and `phase` is data (1) or data-acknowledge (3). It never runs in address (0) or address-acknowledge (2), and never with `smbus`=0.
- R10: Within a transfer, SCL rises are numbered 0 to 8 and the count wraps after 8. An SDA edge while SCL is high sets flag bit 0 at positions 1 to 8. At position 0, or with the bus idle, the edge is a legal start or stop.
- R11: `master_go` sets `is_master` and `master_end` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Peripheral enable; low clears all state |
| no_stretch | input | 1 | Clock stretching disabled |
| ack_en | input | 1 | Acknowledge enable |
| pec_ctl | input | 1 | Check-byte handling requested |
| smbus | input | 1 | SMBus operation |
| scl_in | input | 1 | Synchronized SCL |
| sda_in | input | 1 | Synchronized SDA |
| sda_drv | input | 1 | Level this unit drives on SDA (1 = released) |
| sda_own | input | 1 | This unit is driving the current SDA bit |
| phase | input | 2 | 0 address, 1 data, 2 address ack, 3 data ack |
| master_go | input | 1 | Strobe: master mode entered |
| master_end | input | 1 | Strobe: master mode left |
| rx_done | input | 1 | Strobe: byte and its ack received |
| dr_unread | input | 1 | Data register still holds an unread byte |
| tx_need | input | 1 | Strobe: next byte must be sent |
| dr_loaded | input | 1 | Data register holds a fresh byte to send |
| ack_smp | input | 1 | Strobe: acknowledge bit sampled after a sent byte |
| ack_nack | input | 1 | Sampled acknowledge level (1 = not acknowledged) |
| pec_done | input | 1 | Strobe: check byte compared |
| pec_match | input | 1 | Check byte matched |
| clr_we | input | 1 | Software write strobe for the flag register |
| clr_val | input | 5 | Write data; 0 clears the flag at that position |
| flags | output | 5 | Sticky error flags |
| is_master | output | 1 | Master mode |
| rx_drop | output | 1 | Pulse: received byte is dropped |
| tx_repeat | output | 1 | Pulse: previous byte is sent again |
| pec_ack_vld | output | 1 | Pulse: acknowledge decision for the check byte is valid |
| pec_ack | output | 1 | 1 = acknowledge the check byte, 0 = NACK |

## Verification
The assertions assume that SCL and SDA are already synchronized and that each strobe lasts one system clock. They also assume that `en` is set from a register and does not toggle for a single cycle in the middle of a test. The bench changes the bus lines only on falling system clock edges and holds each level for two cycles, so the registered copy of the lines has always caught up before the next change. It releases `sda_own` outside the arbitration cases, which keeps a stop condition from being mistaken for a lost bit. Each sweep starts from an idle bus with all flags cleared.

// File: rtl/i2c_flag_pkg.sv
// Shared constants and types for the I2C error flag unit.
// Assumes: flag positions are fixed, because software decodes them.
package i2c_flag_pkg;

    localparam int NUM_FLAGS = 5;
    localparam int F_BERR    = 0;
    localparam int F_ARLO    = 1;
    localparam int F_AF      = 2;
    localparam int F_OVR     = 3;
    localparam int F_PEC     = 4;

    typedef enum logic [1:0] {
        PH_ADDR     = 2'd0,
        PH_DATA     = 2'd1,
        PH_ADDR_ACK = 2'd2,
        PH_DATA_ACK = 2'd3
    } phase_e;

endpackage

// File: rtl/i2c_bus_monitor.sv
// Watches the synchronized bus lines and finds start, stop and SCL rising
// edges. It numbers the SCL rises inside each byte (data bits plus ack) and
// reports an SDA edge during SCL high at any position other than the first.
// Assumes: scl/sda are already synchronized to clk.
module i2c_bus_monitor #(
    parameter int BITS_PER_BYTE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic misplaced
);
    localparam int SLOTS = BITS_PER_BYTE + 1;
    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    logic             scl_d, sda_d;
    logic             busy, fresh;
    logic [IDX_W-1:0] bit_idx;
    logic             scl_hi, sda_fall, sda_rise;

    // Edge and condition decode against the previous sample.
    always_comb begin
        scl_hi    = scl & scl_d;
        sda_fall  = scl_hi & sda_d & ~sda;
        sda_rise  = scl_hi & ~sda_d & sda;
        scl_rise  = scl & ~scl_d;
        misplaced = busy & ~fresh & (bit_idx != '0) & (sda_fall | sda_rise);
    end

    // Line samples, bus-busy tracking and bit position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            busy    <= 1'b0;
            fresh   <= 1'b0;
            bit_idx <= '0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            if (sda_fall) begin
                busy  <= 1'b1;
                fresh <= 1'b1;
            end else if (sda_rise) begin
                busy  <= 1'b0;
                fresh <= 1'b0;
            end else if (scl_rise && busy) begin
                if (fresh) begin
                    fresh   <= 1'b0;
                    bit_idx <= '0;
                end else if (bit_idx == LAST_IDX) begin
                    bit_idx <= '0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    a_r10_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= LAST_IDX);

endmodule

// File: rtl/i2c_flag_events.sv
// Turns bus observations and byte-engine strobes into flag set requests.
// Holds the master mode bit and the registered per-byte decisions.
// Assumes: every strobe is one clk wide.
module i2c_flag_events
    import i2c_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 no_stretch,
    input  logic                 ack_en,
    input  logic                 pec_ctl,
    input  logic                 smbus,
    input  phase_e               phase,
    input  logic                 sda,
    input  logic                 sda_drv,
    input  logic                 sda_own,
    input  logic                 scl_rise,
    input  logic                 misplaced,
    input  logic                 master_go,
    input  logic                 master_end,
    input  logic                 rx_done,
    input  logic                 dr_unread,
    input  logic                 tx_need,
    input  logic                 dr_loaded,
    input  logic                 ack_smp,
    input  logic                 ack_nack,
    input  logic                 pec_done,
    input  logic                 pec_match,
    output logic [NUM_FLAGS-1:0] set_vec,
    output logic                 is_master,
    output logic                 rx_drop,
    output logic                 tx_repeat,
    output logic                 pec_ack_vld,
    output logic                 pec_ack
);
    logic arb_window, arb_lost, slave_nostr, ovr_rx, udr_tx, pec_bad;

    // Set conditions for each flag, all gated by the enable.
    always_comb begin
        arb_window = is_master |
                     (smbus & ((phase == PH_DATA) | (phase == PH_DATA_ACK)));
        arb_lost   = en & scl_rise & sda_own & sda_drv & ~sda & arb_window;
        slave_nostr = en & ~is_master & no_stretch;
        ovr_rx     = slave_nostr & rx_done & dr_unread;
        udr_tx     = slave_nostr & tx_need & ~dr_loaded;
        pec_bad    = en & pec_done & ~pec_match & (is_master | pec_ctl);
        set_vec         = '0;
        set_vec[F_BERR] = en & misplaced;
        set_vec[F_ARLO] = arb_lost;
        set_vec[F_AF]   = en & ack_smp & ack_nack;
        set_vec[F_OVR]  = ovr_rx | udr_tx;
        set_vec[F_PEC]  = pec_bad;
    end

    // Master mode bit: entered on request, left on end or arbitration loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            is_master <= 1'b0;
        end else if (arb_lost || master_end) begin
            is_master <= 1'b0;
        end else if (master_go) begin
            is_master <= 1'b1;
        end
    end

    // Registered per-byte decisions for the byte engine.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            rx_drop     <= 1'b0;
            tx_repeat   <= 1'b0;
            pec_ack_vld <= 1'b0;
            pec_ack     <= 1'b0;
        end else begin
            rx_drop     <= ovr_rx;
            tx_repeat   <= udr_tx;
            pec_ack_vld <= pec_done;
            pec_ack     <= pec_done & pec_match & ack_en;
        end
    end

    a_r3_pec_mismatch_nacks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pec_done && !pec_match) |=> (pec_ack_vld && !pec_ack));

    a_r8_arb_loss_to_slave: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_master && scl_rise && sda_own && sda_drv && !sda) |=> !is_master);

    a_r5_stretch_blocks_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !no_stretch |=> (!rx_drop && !tx_repeat));

    a_r9_addr_ack_no_arb: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && phase == PH_ADDR_ACK) |-> !set_vec[F_ARLO]);

endmodule

// File: rtl/i2c_flag_bank.sv
// Sticky flag register: set by hardware, cleared by a software write of 0,
// cleared as a whole while the enable is low. Set wins over clear.
// Assumes: clr_we is a single-cycle write strobe.
module i2c_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_val,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag bit: set, write-zero clear, disable clear.
        always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
                q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                q[i] <= 1'b1;
            end else if (clr_we && !clr_val[i]) begin
                q[i] <= 1'b0;
            end
        end

        a_r2_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (en && clr_we && clr_val[i] && q[i]) |=> q[i]);

        a_r2_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (en && clr_we && !clr_val[i] && !set_vec[i]) |=> !q[i]);
    end

    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q == '0));

endmodule

// File: rtl/i2c_err_flags.sv
// Top of the I2C error flag unit: bus monitor, event evaluation and the
// sticky flag bank. Assumes synchronized bus lines and one-cycle strobes.
module i2c_err_flags
    import i2c_flag_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 no_stretch,
    input  logic                 ack_en,
    input  logic                 pec_ctl,
    input  logic                 smbus,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 sda_drv,
    input  logic                 sda_own,
    input  logic [1:0]           phase,
    input  logic                 master_go,
    input  logic                 master_end,
    input  logic                 rx_done,
    input  logic                 dr_unread,
    input  logic                 tx_need,
    input  logic                 dr_loaded,
    input  logic                 ack_smp,
    input  logic                 ack_nack,
    input  logic                 pec_done,
    input  logic                 pec_match,
    input  logic                 clr_we,
    input  logic [NUM_FLAGS-1:0] clr_val,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 is_master,
    output logic                 rx_drop,
    output logic                 tx_repeat,
    output logic                 pec_ack_vld,
    output logic                 pec_ack
);
    logic                 scl_rise, misplaced;
    logic [NUM_FLAGS-1:0] set_vec;
    phase_e               phase_q;

    // Map the raw phase code onto the shared type.
    always_comb phase_q = phase_e'(phase);

    i2c_bus_monitor #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_in),
        .sda       (sda_in),
        .scl_rise  (scl_rise),
        .misplaced (misplaced)
    );

    i2c_flag_events u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .no_stretch  (no_stretch),
        .ack_en      (ack_en),
        .pec_ctl     (pec_ctl),
        .smbus       (smbus),
        .phase       (phase_q),
        .sda         (sda_in),
        .sda_drv     (sda_drv),
        .sda_own     (sda_own),
        .scl_rise    (scl_rise),
        .misplaced   (misplaced),
        .master_go   (master_go),
        .master_end  (master_end),
        .rx_done     (rx_done),
        .dr_unread   (dr_unread),
        .tx_need     (tx_need),
        .dr_loaded   (dr_loaded),
        .ack_smp     (ack_smp),
        .ack_nack    (ack_nack),
        .pec_done    (pec_done),
        .pec_match   (pec_match),
        .set_vec     (set_vec),
        .is_master   (is_master),
        .rx_drop     (rx_drop),
        .tx_repeat   (tx_repeat),
        .pec_ack_vld (pec_ack_vld),
        .pec_ack     (pec_ack)
    );

    i2c_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .set_vec (set_vec),
        .clr_we  (clr_we),
        .clr_val (clr_val),
        .q       (flags)
    );

    a_r11_go_enters_master: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master_go && !master_end && !set_vec[F_ARLO]) |=> is_master);

endmodule

// File: tb/i2c_err_flags_bench.sv
`timescale 1ns/1ps
module i2c_err_flags_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, no_stretch = 1'b0, ack_en = 1'b0, pec_ctl = 1'b0, smbus = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, sda_drv = 1'b1, sda_own = 1'b0;
    logic [1:0] phase = 2'd0;
    logic master_go = 1'b0, master_end = 1'b0;
    logic rx_done = 1'b0, dr_unread = 1'b0, tx_need = 1'b0, dr_loaded = 1'b0;
    logic ack_smp = 1'b0, ack_nack = 1'b0, pec_done = 1'b0, pec_match = 1'b0;
    logic clr_we = 1'b0;
    logic [4:0] clr_val = 5'd0;
    logic [4:0] flags;
    logic is_master, rx_drop, tx_repeat, pec_ack_vld, pec_ack;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_err_flags u_i2c_err_flags (
        .clk(clk), .rst_n(rst_n), .en(en), .no_stretch(no_stretch),
        .ack_en(ack_en), .pec_ctl(pec_ctl), .smbus(smbus),
        .scl_in(scl_in), .sda_in(sda_in), .sda_drv(sda_drv), .sda_own(sda_own),
        .phase(phase), .master_go(master_go), .master_end(master_end),
        .rx_done(rx_done), .dr_unread(dr_unread), .tx_need(tx_need),
        .dr_loaded(dr_loaded), .ack_smp(ack_smp), .ack_nack(ack_nack),
        .pec_done(pec_done), .pec_match(pec_match), .clr_we(clr_we),
        .clr_val(clr_val), .flags(flags), .is_master(is_master),
        .rx_drop(rx_drop), .tx_repeat(tx_repeat), .pec_ack_vld(pec_ack_vld),
        .pec_ack(pec_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic s, input logic d);
        @(negedge clk);
        scl_in = s;
        sda_in = d;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_we = 1'b1;
        clr_val = 5'd0;
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        master_end = 1'b1;
        @(negedge clk);
        master_end = 1'b0;
        if (m) begin
            master_go = 1'b1;
            @(negedge clk);
            master_go = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset flags", flags, 0);
        chk("R1 reset master", is_master, 0);
        chk("R1 reset pec valid", pec_ack_vld, 0);

        // R11: master mode entry and exit
        set_mode(1'b1);
        chk("R11 go", is_master, 1);
        set_mode(1'b0);
        chk("R11 end", is_master, 0);

        // R10: SDA edge at each SCL-high position, including the wrap
        for (int k = 0; k < 10; k++) begin
            bus(1'b1, 1'b1);
            clear_all();
            bus(1'b1, 1'b0);
            for (int i = 0; i <= k; i++) begin
                bus(1'b0, 1'b0);
                bus(1'b1, 1'b0);
            end
            bus(1'b1, 1'b1);
            chk($sformatf("R10 position %0d", k), flags[0], ((k % 9) != 0));
        end
        clear_all();
        bus(1'b1, 1'b0);
        bus(1'b1, 1'b1);
        chk("R10 idle start stop legal", flags[0], 0);

        // R8 R9: arbitration sweep over mode, smbus, phase and driven level
        for (int m = 0; m < 2; m++)
            for (int sb = 0; sb < 2; sb++)
                for (int ph = 0; ph < 4; ph++)
                    for (int dv = 0; dv < 2; dv++) begin
                        logic exp;
                        exp = (dv == 1) && ((m == 1) || ((sb == 1) && (ph == 1 || ph == 3)));
                        set_mode(m[0]);
                        clear_all();
                        smbus = sb[0];
                        phase = ph[1:0];
                        sda_own = 1'b1;
                        sda_drv = dv[0];
                        bus(1'b0, 1'b0);
                        bus(1'b1, 1'b0);
                        chk($sformatf("R8 R9 arb m=%0d sb=%0d ph=%0d dv=%0d", m, sb, ph, dv),
                            flags[1], exp);
                        chk($sformatf("R8 mode m=%0d sb=%0d ph=%0d dv=%0d", m, sb, ph, dv),
                            is_master, (m == 1) && !exp);
                        sda_own = 1'b0;
                        sda_drv = 1'b1;
                    end
        bus(1'b1, 1'b1);
        smbus = 1'b0;

        // R3 R4: check-byte sweep
        for (int m = 0; m < 2; m++)
            for (int pc = 0; pc < 2; pc++)
                for (int ae = 0; ae < 2; ae++)
                    for (int mt = 0; mt < 2; mt++) begin
                        set_mode(m[0]);
                        clear_all();
                        @(negedge clk);
                        pec_ctl = pc[0];
                        ack_en = ae[0];
                        pec_match = mt[0];
                        pec_done = 1'b1;
                        @(negedge clk);
                        pec_done = 1'b0;
                        chk("R3 pec valid", pec_ack_vld, 1);
                        chk($sformatf("R3 pec ack ae=%0d mt=%0d", ae, mt), pec_ack,
                            (ae == 1) && (mt == 1));
                        chk($sformatf("R4 pec err m=%0d pc=%0d mt=%0d", m, pc, mt), flags[4],
                            (mt == 0) && ((m == 1) || (pc == 1)));
                        @(negedge clk);
                        chk("R3 pec valid single", pec_ack_vld, 0);
                    end
        pec_ctl = 1'b0;

        // R5 R6: overrun and underrun sweep
        for (int m = 0; m < 2; m++)
            for (int ns = 0; ns < 2; ns++)
                for (int kd = 0; kd < 2; kd++)
                    for (int st = 0; st < 2; st++) begin
                        logic exp;
                        exp = (m == 0) && (ns == 1) && (st == 1);
                        set_mode(m[0]);
                        clear_all();
                        @(negedge clk);
                        no_stretch = ns[0];
                        if (kd == 0) begin
                            rx_done = 1'b1;
                            dr_unread = st[0];
                        end else begin
                            tx_need = 1'b1;
                            dr_loaded = !st[0];
                        end
                        @(negedge clk);
                        rx_done = 1'b0;
                        tx_need = 1'b0;
                        chk($sformatf("R5 R6 ovr m=%0d ns=%0d kd=%0d st=%0d", m, ns, kd, st),
                            flags[3], exp);
                        chk("R5 rx_drop", rx_drop, exp && (kd == 0));
                        chk("R6 tx_repeat", tx_repeat, exp && (kd == 1));
                        dr_unread = 1'b0;
                        dr_loaded = 1'b0;
                    end
        set_mode(1'b0);

        // R7: acknowledge failure
        for (int nk = 0; nk < 2; nk++) begin
            clear_all();
            @(negedge clk);
            ack_smp = 1'b1;
            ack_nack = nk[0];
            @(negedge clk);
            ack_smp = 1'b0;
            chk($sformatf("R7 af nack=%0d", nk), flags[2], nk);
        end

        // R2: write-zero clear sweep over every write pattern
        for (int p = 0; p < 32; p++) begin
            clear_all();
            @(negedge clk);
            no_stretch = 1'b1;
            pec_ctl = 1'b1;
            ack_smp = 1'b1; ack_nack = 1'b1;
            rx_done = 1'b1; dr_unread = 1'b1;
            pec_done = 1'b1; pec_match = 1'b0;
            @(negedge clk);
            ack_smp = 1'b0; rx_done = 1'b0; pec_done = 1'b0;
            chk("R2 preset", flags, 5'b11100);
            clr_we = 1'b1;
            clr_val = p[4:0];
            @(negedge clk);
            clr_we = 1'b0;
            chk($sformatf("R2 write %0h", p), flags, p[4:0] & 5'b11100);
        end

        // R2: set beats clear in the same cycle
        clear_all();
        @(negedge clk);
        ack_smp = 1'b1; ack_nack = 1'b1;
        clr_we = 1'b1; clr_val = 5'd0;
        @(negedge clk);
        ack_smp = 1'b0; clr_we = 1'b0;
        chk("R2 set wins", flags[2], 1);

        // R1: disable clears and blocks
        set_mode(1'b1);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R1 disable flags", flags, 0);
        chk("R1 disable master", is_master, 0);
        ack_smp = 1'b1; ack_nack = 1'b1; master_go = 1'b1;
        @(negedge clk);
        ack_smp = 1'b0; master_go = 1'b0;
        chk("R1 disabled af ignored", flags, 0);
        chk("R1 disabled go ignored", is_master, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R1 reenabled flags", flags, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule